// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the 32-bit control register file of a PCI host bridge. It sits on a simple single-cycle read/write bus and decodes the low 16 address bits. It holds a small set of IOMMU control words, one interrupt map register per interrupt group, a bank of PCI control words, and a reset control/status register. Software asks for a soft reset by writing that register, and the block answers with a one-cycle system reset request.

Two resets reach the block. `rst_n` is the power-up reset and clears everything. `sys_rst` is a synchronous system reset, one cycle wide, that the surrounding chip raises when it resets the system. On each system reset the block turns off every interrupt map enable. On the first system reset after power-up, or the first after a soft power-on request, it also records power-on status in the reset register. Address ranges that belong to functions outside this block read as zero and ignore writes: DMA error logging, IOMMU flush, the diagnostic spaces and the memory controller.

A read returns its data one cycle after the request. Writes take effect at the clock edge on which they are presented.

Top module: `hb_ctrl_regs`

## Requirements
- R1: After `rst_n` the IOMMU words, PCI control words and reset register read 0. Interrupt map i reads (0x1F << 6) | (i << 2) with bit 31 clear. `reset_req` and `bus_rvalid` are low.
- R2: Offsets 0x200, 0x204 and 0x208 are three fully writable and readable IOMMU words, selected by address bits [3:2]. Writes to 0x20C–0x3FF change nothing, and those offsets read 0.
- R3: The eight interrupt map registers sit at 0xC04 + 8·i, with the index taken from address bits [5:3]. The word at 0xC00 + 8·i (address bit 2 clear) reads 0 and ignores writes.
- R4: A write to an interrupt map register updates only bit 31, the enable bit. Bits [30:0] keep their value.
- R5: Offsets 0x2000–0x202C hold twelve fully writable and readable PCI control words, selected by address bits [5:2].
- R6: The reset register is read and written at 0xF024. Offset 0xF020 reads 0. A written value is first masked with 0xF8000000. A 1 in bit 31, 28 or 27 clears that bit, and a 0 leaves it unchanged. Bits 30 and 29 take the written value.
- R7: A reset register write with bit 30 set makes `reset_req` high for exactly the next cycle and rearms the power-on flag. A write with bit 30 clear and bit 29 set also produces the one-cycle request. Any other write produces no request.
- R8: A `sys_rst` cycle clears bit 31 of all eight interrupt map registers. It leaves the IOMMU words, the PCI control words and bits [30:0] of the maps unchanged.
- R9: A `sys_rst` while the power-on flag is armed loads the reset register with 0x80000000 and disarms the flag. The flag is armed by `rst_n` and by a soft power-on write. A `sys_rst` while the flag is disarmed leaves the reset register unchanged.
- R10: Every offset outside the decoded words reads 0 and ignores writes. Examples are 0x0030, 0x5000, 0xA800, 0xF000 and 0x1234.
- R11: A read request produces `bus_rvalid` and `bus_rdata` in the following cycle, with the state that was in place before that edge. A write presented in a `sys_rst` cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| sys_rst | input | 1 | Synchronous system reset pulse |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the request |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench goes after the reset register most of all. It checks that the write mask is applied, that bit 31 is cleared by writing 1 rather than loaded, and that the soft bits are replaced rather than ORed in. A design that reloaded power-on status on every system reset would show 0x80000000 where the bench expects 0x20000000. A design that forgot to rearm the flag on a soft power-on write would show 0x40000000 where the bench expects 0x80000000. Interrupt map writes of all-ones and of zero show whether the low bits leak, and a bank that ignored address bit 2 would store data written to the dead word. A write held in the same cycle as `sys_rst`, and writes to the flush and undecoded ranges, expose a design that lets either kind of write through.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
   localparam int DW = 32;
   localparam int AW = 16;

   typedef enum logic [2:0] {
      RG_NONE   = 3'd0,
      RG_IOMMU  = 3'd1,
      RG_IRQMAP = 3'd2,
      RG_PCICTL = 3'd3,
      RG_RSTCTL = 3'd4
   } hbr_region_e;

   // Address map (byte offsets)
   localparam int IOMMU_BASE  = 'h0200;
   localparam int FLUSH_LAST  = 'h03FF;
   localparam int IRQ_BASE    = 'h0C00;
   localparam int PCI_BASE    = 'h2000;
   localparam int RST_BASE    = 'h F020;

   // Reset register bit roles
   localparam logic [DW-1:0] RST_KEEP_MASK = 32'hF800_0000;
   localparam logic [DW-1:0] RST_W1C_MASK  = 32'h9800_0000;
   localparam logic [DW-1:0] RST_LOAD_MASK = 32'h6000_0000;
   localparam logic [DW-1:0] RST_POR_VALUE = 32'h8000_0000;
   localparam int SOFT_POR_BIT = 30;
   localparam int SOFT_XIR_BIT = 29;

   // Interrupt map fixed fields
   localparam int IRQ_EN_BIT   = 31;
   localparam int IRQ_GRP_BASE = 'h7C0;
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
   import hbr_pkg::*;
#(
   parameter int IOMMU_WORDS = 3,
   parameter int IRQ_MAPS    = 8,
   parameter int PCI_WORDS   = 12
) (
   input  logic [AW-1:0] addr,
   output hbr_region_e   region,
   output logic [3:0]    idx
);
   localparam int IOMMU_LAST = IOMMU_BASE + 4 * IOMMU_WORDS - 1;
   localparam int IRQ_LAST   = IRQ_BASE + 8 * IRQ_MAPS - 1;
   localparam int PCI_LAST   = PCI_BASE + 4 * PCI_WORDS - 1;
   localparam int RST_LAST   = RST_BASE + 7;

   int a;

   always_comb begin
      a      = int'(addr);
      region = RG_NONE;
      idx    = 4'd0;
      if (a >= IOMMU_BASE && a <= IOMMU_LAST) begin
         region = RG_IOMMU;
         idx    = {2'b00, addr[3:2]};
      end else if (a > IOMMU_LAST && a <= FLUSH_LAST) begin
         region = RG_NONE;
      end else if (a >= IRQ_BASE && a <= IRQ_LAST) begin
         if (addr[2]) begin
            region = RG_IRQMAP;
            idx    = {1'b0, addr[5:3]};
         end
      end else if (a >= PCI_BASE && a <= PCI_LAST) begin
         region = RG_PCICTL;
         idx    = addr[5:2];
      end else if (a >= RST_BASE && a <= RST_LAST) begin
         if (addr[2]) region = RG_RSTCTL;
      end
   end
endmodule

// File: rtl/hbr_word_bank.sv
module hbr_word_bank #(
   parameter int WORDS = 3,
   parameter int IW    = 2,
   parameter int DW    = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   generate
      if (WORDS < 1 || WORDS > (1 << IW)) begin : g_bad_words
         $error("hbr_word_bank: WORDS must fit the index field");
      end
   endgenerate

   logic [DW-1:0] word_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < WORDS; i++)
            if (int'(wr_idx) == i) word_q[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < WORDS; i++)
         if (int'(rd_idx) == i) rd_data = word_q[i];
   end

   // R2 R5
   word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (int'(wr_idx) < WORDS) |=> word_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/hbr_irq_map.sv
module hbr_irq_map
   import hbr_pkg::*;
#(
   parameter int MAPS = 8,
   parameter int IW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sys_rst,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_enable,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   generate
      if (MAPS < 1 || MAPS > (1 << IW)) begin : g_bad_maps
         $error("hbr_irq_map: MAPS must fit the index field");
      end
   endgenerate

   logic [MAPS-1:0] en_q;
   logic [DW-1:0]   map_val [MAPS];

   // Bits [30:0] never change after power-up, so they are constants.
   generate
      for (genvar g = 0; g < MAPS; g++) begin : g_map
         localparam logic [30:0] FIXED = 31'(IRQ_GRP_BASE | (g << 2));
         assign map_val[g] = {en_q[g], FIXED};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (sys_rst) begin
         en_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < MAPS; i++)
            if (int'(wr_idx) == i) en_q[i] <= wr_enable;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < MAPS; i++)
         if (int'(rd_idx) == i) rd_data = map_val[i];
   end

   // R8
   irq_en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> en_q == '0);
   // R4
   irq_en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !sys_rst && (int'(wr_idx) < MAPS) |=> en_q[$past(wr_idx)] == $past(wr_enable));
endmodule

// File: rtl/hbr_reset_ctl.sv
module hbr_reset_ctl
   import hbr_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sys_rst,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] ctl_q,
   output logic          reset_req
);
   logic          por_armed_q;
   logic [DW-1:0] masked;
   logic [DW-1:0] ctl_next;

   always_comb begin
      masked   = wr_data & RST_KEEP_MASK;
      ctl_next = (ctl_q & ~(masked & RST_W1C_MASK) & ~RST_LOAD_MASK)
               | (masked & RST_LOAD_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q       <= '0;
         por_armed_q <= 1'b1;
         reset_req   <= 1'b0;
      end else begin
         reset_req <= 1'b0;
         if (sys_rst) begin
            por_armed_q <= 1'b0;
            if (por_armed_q) ctl_q <= RST_POR_VALUE;
         end else if (wr_en) begin
            ctl_q <= ctl_next;
            if (masked[SOFT_POR_BIT]) begin
               por_armed_q <= 1'b1;
               reset_req   <= 1'b1;
            end else if (masked[SOFT_XIR_BIT]) begin
               reset_req <= 1'b1;
            end
         end
      end
   end

   // R9
   por_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst && por_armed_q |=> ctl_q == RST_POR_VALUE && !por_armed_q);
   // R9
   por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst && !por_armed_q |=> $stable(ctl_q));
   // R7
   req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(wr_en && !sys_rst));
endmodule

// File: rtl/hb_ctrl_regs.sv
module hb_ctrl_regs
   import hbr_pkg::*;
#(
   parameter int IOMMU_WORDS = 3,
   parameter int IRQ_MAPS    = 8,
   parameter int PCI_WORDS   = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sys_rst,
   input  logic          bus_valid,
   input  logic          bus_write,
   input  logic [15:0]   bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic          bus_rvalid,
   output logic [31:0]   bus_rdata,
   output logic          reset_req
);
   localparam int IOMMU_IW = 2;
   localparam int IRQ_IW   = 3;
   localparam int PCI_IW   = 4;

   hbr_region_e   region;
   logic [3:0]    idx;
   logic          wr_any;
   logic [DW-1:0] iommu_rd, irq_rd, pci_rd, rst_rd, rd_mux;

   assign wr_any = bus_valid && bus_write && !sys_rst;

   hbr_decode #(
      .IOMMU_WORDS(IOMMU_WORDS), .IRQ_MAPS(IRQ_MAPS), .PCI_WORDS(PCI_WORDS)
   ) u_decode (
      .addr(bus_addr), .region(region), .idx(idx)
   );

   hbr_word_bank #(.WORDS(IOMMU_WORDS), .IW(IOMMU_IW), .DW(DW)) u_iommu (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_any && region == RG_IOMMU),
      .wr_idx(idx[IOMMU_IW-1:0]), .wr_data(bus_wdata),
      .rd_idx(idx[IOMMU_IW-1:0]), .rd_data(iommu_rd)
   );

   hbr_word_bank #(.WORDS(PCI_WORDS), .IW(PCI_IW), .DW(DW)) u_pcictl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_any && region == RG_PCICTL),
      .wr_idx(idx[PCI_IW-1:0]), .wr_data(bus_wdata),
      .rd_idx(idx[PCI_IW-1:0]), .rd_data(pci_rd)
   );

   hbr_irq_map #(.MAPS(IRQ_MAPS), .IW(IRQ_IW)) u_irqmap (
      .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
      .wr_en(wr_any && region == RG_IRQMAP),
      .wr_idx(idx[IRQ_IW-1:0]), .wr_enable(bus_wdata[IRQ_EN_BIT]),
      .rd_idx(idx[IRQ_IW-1:0]), .rd_data(irq_rd)
   );

   hbr_reset_ctl u_rstctl (
      .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
      .wr_en(wr_any && region == RG_RSTCTL),
      .wr_data(bus_wdata), .ctl_q(rst_rd), .reset_req(reset_req)
   );

   always_comb begin
      unique case (region)
         RG_IOMMU:  rd_mux = iommu_rd;
         RG_IRQMAP: rd_mux = irq_rd;
         RG_PCICTL: rd_mux = pci_rd;
         RG_RSTCTL: rd_mux = rst_rd;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_valid && !bus_write;
         bus_rdata  <= (bus_valid && !bus_write) ? rd_mux : '0;
      end
   end

   // R11
   rd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_valid && !bus_write));
   // R10
   undecoded_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_write && region == RG_NONE |=> bus_rdata == '0);
endmodule

// File: tb/hb_ctrl_regs_tb.sv
module hb_ctrl_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_rst = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [31:0] bus_rdata;
   logic        reset_req;

   always #10ns clk = ~clk;

   hb_ctrl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .reset_req(reset_req)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // Behavioural reference state
   logic [31:0] m_iommu [3];
   logic [31:0] m_pci [12];
   bit          m_en [8];
   logic [31:0] m_rst;
   bit          m_armed;
   bit          exp_rv;
   logic [31:0] exp_rd;
   bit          exp_req;
   string       exp_tag;

   function automatic logic [31:0] model_read(int a);
      if (a >= 'h200 && a <= 'h20B) return m_iommu[(a >> 2) & 3];
      if (a >= 'hC00 && a <= 'hC3F) begin
         if ((a & 4) == 0) return 32'h0;
         return {m_en[(a >> 3) & 7], 31'('h7C0 + (((a >> 3) & 7) * 4))};
      end
      if (a >= 'h2000 && a <= 'h202F) return m_pci[(a >> 2) & 15];
      if (a >= 'hF024 && a <= 'hF027) return m_rst;
      return 32'h0;
   endfunction

   task automatic model_write(int a, logic [31:0] d);
      logic [31:0] v;
      if (a >= 'h200 && a <= 'h20B) m_iommu[(a >> 2) & 3] = d;
      else if (a >= 'hC00 && a <= 'hC3F) begin
         if ((a & 4) != 0) m_en[(a >> 3) & 7] = d[31];
      end
      else if (a >= 'h2000 && a <= 'h202F) m_pci[(a >> 2) & 15] = d;
      else if (a >= 'hF024 && a <= 'hF027) begin
         v = d & 32'hF800_0000;
         for (int b = 27; b < 32; b++) begin
            if (b == 29 || b == 30) m_rst[b] = v[b];
            else if (v[b]) m_rst[b] = 1'b0;
         end
         if (v[30]) begin m_armed = 1; exp_req = 1; end
         else if (v[29]) exp_req = 1;
      end
   endtask

   task automatic compare();
      checks++;
      if (reset_req !== exp_req) begin
         failures++;
         $display("FAIL %s reset_req act=%0b exp=%0b", exp_tag, reset_req, exp_req);
      end
      checks++;
      if (bus_rvalid !== exp_rv) begin
         failures++;
         $display("FAIL %s bus_rvalid act=%0b exp=%0b", exp_tag, bus_rvalid, exp_rv);
      end
      if (exp_rv) begin
         checks++;
         if (bus_rdata !== exp_rd) begin
            failures++;
            $display("FAIL %s bus_rdata act=%h exp=%h", exp_tag, bus_rdata, exp_rd);
         end
      end
   endtask

   // One bus cycle: check the previous cycle's outcome, then drive the next.
   task automatic step(bit v, bit w, int a, logic [31:0] d, bit s, string tag);
      @(negedge clk);
      compare();
      bus_valid = v; bus_write = w; bus_addr = 16'(a); bus_wdata = d; sys_rst = s;
      exp_tag = tag;
      exp_rv  = v && !w;
      exp_rd  = model_read(a);
      exp_req = 0;
      if (s) begin
         for (int i = 0; i < 8; i++) m_en[i] = 0;
         if (m_armed) m_rst = 32'h8000_0000;
         m_armed = 0;
      end else if (v && w) begin
         model_write(a, d);
      end
   endtask

   task automatic rd(int a, string tag);  step(1, 0, a, 32'h0, 0, tag); endtask
   task automatic wr(int a, logic [31:0] d, string tag); step(1, 1, a, d, 0, tag); endtask
   task automatic idle(string tag); step(0, 0, 0, 32'h0, 0, tag); endtask
   task automatic sysrst(string tag); step(0, 0, 0, 32'h0, 1, tag); endtask

   task automatic read_all(string tag);
      for (int i = 0; i < 3; i++) rd('h200 + 4 * i, tag);
      for (int i = 0; i < 8; i++) rd('hC04 + 8 * i, tag);
      for (int i = 0; i < 12; i++) rd('h2000 + 4 * i, tag);
      rd('hF024, tag);
   endtask

   initial begin
      for (int i = 0; i < 3; i++) m_iommu[i] = 0;
      for (int i = 0; i < 12; i++) m_pci[i] = 0;
      for (int i = 0; i < 8; i++) m_en[i] = 0;
      m_rst = 0; m_armed = 1;
      exp_rv = 0; exp_rd = 0; exp_req = 0; exp_tag = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 power-up values
      idle("R1");
      read_all("R1");
      rd('hF020, "R6");

      // R2 IOMMU words and flush range
      for (int i = 0; i < 3; i++) wr('h200 + 4 * i, 32'hA5A5_0000 + i, "R2");
      wr('h20C, 32'hFFFF_FFFF, "R2");
      wr('h300, 32'h1234_5678, "R2");
      wr('h3FC, 32'hFFFF_FFFF, "R2");
      for (int i = 0; i < 3; i++) rd('h200 + 4 * i, "R2");
      rd('h20C, "R2"); rd('h3FC, "R2");

      // R3 R4 interrupt maps
      for (int i = 0; i < 8; i++) wr('hC04 + 8 * i, 32'hFFFF_FFFF, "R4");
      for (int i = 0; i < 8; i++) wr('hC00 + 8 * i, 32'h0000_0000, "R3");
      for (int i = 0; i < 8; i++) rd('hC04 + 8 * i, "R4");
      for (int i = 0; i < 8; i++) rd('hC00 + 8 * i, "R3");
      wr('hC0C, 32'h7FFF_FFFF, "R4");
      rd('hC0C, "R4");

      // R5 PCI control words
      for (int i = 0; i < 12; i++) wr('h2000 + 4 * i, 32'h3C00_0000 ^ (i * 32'h0101_0101), "R5");
      for (int i = 0; i < 12; i++) rd('h2000 + 4 * i, "R5");

      // R8 R9 first system reset loads power-on status
      sysrst("R8");
      read_all("R8");
      rd('hF024, "R9");

      // R6 write-one-to-clear bit 31, then soft XIR load and request
      for (int i = 0; i < 8; i++) wr('hC04 + 8 * i, 32'h8000_0000, "R8");
      wr('hF024, 32'h8000_0000, "R6");
      rd('hF024, "R6");
      wr('hF024, 32'h2000_0000, "R7");
      idle("R7");
      rd('hF024, "R6");
      wr('hF020, 32'hFFFF_FFFF, "R6");
      rd('hF020, "R6");
      rd('hF024, "R6");

      // R9 second system reset keeps the register
      sysrst("R9");
      rd('hF024, "R9");
      rd('hC04, "R8");

      // R7 R9 soft power-on rearms the flag
      wr('hF024, 32'h4000_0000, "R7");
      idle("R7");
      rd('hF024, "R6");
      sysrst("R9");
      rd('hF024, "R9");

      // R6 mask and mixed write
      wr('hF024, 32'hFFFF_FFFF, "R6");
      rd('hF024, "R6");
      wr('hF024, 32'h07FF_FFFF, "R7");
      idle("R7");
      rd('hF024, "R6");

      // R11 write in a system reset cycle is dropped
      step(1, 1, 'h200, 32'hDEAD_BEEF, 1, "R11");
      step(1, 1, 'h2004, 32'hDEAD_BEEF, 1, "R11");
      rd('h200, "R11");
      rd('h2004, "R11");
      wr('h204, 32'h0BAD_F00D, "R11");
      rd('h204, "R11");

      // R10 undecoded space
      wr('h0030, 32'hFFFF_FFFF, "R10");
      wr('h5000, 32'hFFFF_FFFF, "R10");
      wr('hA800, 32'hFFFF_FFFF, "R10");
      wr('hF000, 32'hFFFF_FFFF, "R10");
      wr('h1234, 32'hFFFF_FFFF, "R10");
      wr('h2030, 32'hFFFF_FFFF, "R10");
      rd('h0030, "R10"); rd('h5000, "R10"); rd('hA800, "R10");
      rd('hF000, "R10"); rd('h1234, "R10"); rd('h2030, "R10");
      read_all("R10");
      idle("R10");
      idle("R10");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule